// File: doc/BRIEF.md
# Peripheral Reset Register Bank

A bank of 32-bit memory-mapped registers that hold the reset state of a set of peripherals. Each register keeps a reset-assert flag in bit 0; a set flag holds the peripheral in reset. Software writes a register to release or re-apply a reset. When the written bit 0 differs from the stored one, the block stores it and sends a one-cycle reset pulse to the decoded target or targets. The block also drives a level reset that always equals the stored flag.

Most registers each serve one peripheral, and indexed groups (UARTs, Ethernet MACs, USB controllers, CAN controllers) sit at consecutive word addresses. A single register serves every channel of the DMA engine at once. A timer register holds one reset flag per timer and has no pulse target. A spare register stores its flag and has no target. All other addresses are unmapped.

Top module: `periph_rst_bank`

## Requirements
- R1: After reset, the DMA, peripheral and spare registers read 0x1. Every level reset output is 1 and every pulse output is 0.
- R2: The timer register (word 11, byte 0x2C) resets to all ones across its N_TMR bits (0xF when N_TMR is 4). A read returns only those bits; the bits above them read 0.
- R3: A write that changes bit 0 of a targeted register raises that target's pulse for exactly one cycle. The pulse appears in the cycle after the write edge, and the pulse is 0 in the cycle that follows.
- R4: A write whose bit 0 equals the stored bit 0 produces no pulse on any output.
- R5: A write always stores its value, whether or not it produces a pulse. A read returns the stored value, and reserved bits (every bit above bit 0 in a single-flag register) read 0.
- R6: The DMA register at word 0 (byte 0x00) drives all N_DMA channel level and pulse outputs together, all at the same value.
- R7: Within each indexed group, target k sits at word base+k, which is byte address 4*(base+k). The word layout is: DMA 0, UART 1-2, MAC 3-4, USB 5-6, CAN 7-10, timer 11, spare 12. The peripheral output bit order is UART0, UART1, MAC0, MAC1, USB0, USB1, CAN0 to CAN3, at bits 0 to 9.
- R8: A write to the timer or spare register stores the value and changes no output.
- R9: A write to an unmapped word (13 and above) changes no state and no output. A read of an unmapped word returns 0.
- R10: Each level reset output equals bit 0 of its register in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for addr_i / wdata_i |
| addr_i | input | ADDR_W (8) | Byte address for both read and write; bits [1:0] ignored |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read of the word at addr_i |
| periph_rst_o | output | 10 | Level reset for each single peripheral |
| periph_pulse_o | output | 10 | One-cycle reset pulse for each single peripheral |
| dma_rst_o | output | N_DMA (8) | Level reset for each DMA channel |
| dma_pulse_o | output | N_DMA (8) | One-cycle reset pulse for each DMA channel |

## Verification
Every word of the address space is written with four values in turn: bit 0 cleared with the upper bits set, bit 0 cleared again, bit 0 set with a mixed upper pattern, and bit 0 set again. These values separate a real change from a repeated value, and they show whether reserved bits leak into reads. Running the same sequence on every word separates four things: group fan-out on the DMA word, index mapping in the peripheral groups, store-only behaviour on the timer and spare words, and full inertness above the map. After each write, the complete output vectors are compared with a model, so a pulse or level that lands on the wrong target is caught.

// File: rtl/prb_pkg.sv
package prb_pkg;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned WORD_BYTES = 4;
  typedef logic [DATA_W-1:0] word_t;
endpackage

// File: rtl/prb_decode.sv
module prb_decode #(
  parameter int unsigned IDX_W = 6,
  parameter int unsigned NS    = 13
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [NS-1:0]    sel_o
);
  for (genvar s = 0; s < NS; s++) begin : g_sel
    assign sel_o[s] = (idx_i == IDX_W'(s));
  end

`ifndef SYNTHESIS
  // R9
  sel_onehot_chk: assert final ($onehot0(sel_o));
`endif
endmodule

// File: rtl/prb_slot.sv
module prb_slot
  import prb_pkg::*;
#(
  parameter int unsigned W   = 1,
  parameter logic [W-1:0] RST = '1
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  we_i,
  input  word_t wdata_i,
  output word_t val_o,
  output logic  lvl_o,
  output logic  pls_o
);
  logic [W-1:0] q;
  logic         pls_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q     <= RST;
      pls_q <= 1'b0;
    end else begin
      pls_q <= we_i & (wdata_i[0] ^ q[0]);
      if (we_i) q <= wdata_i[W-1:0];
    end
  end

  assign val_o = DATA_W'(q);
  assign lvl_o = q[0];
  assign pls_o = pls_q;

  // R3
  edge_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (wdata_i[0] != lvl_o)) |=> pls_o);
  // R4
  same_bit_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i || (wdata_i[0] == lvl_o)) |=> !pls_o);
  // R10
  pulse_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pls_o |-> (lvl_o != $past(lvl_o)));
  // R5
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(val_o));
endmodule

// File: rtl/periph_rst_bank.sv
module periph_rst_bank
  import prb_pkg::*;
#(
  parameter int unsigned N_UART = 2,
  parameter int unsigned N_GEM  = 2,
  parameter int unsigned N_USB  = 2,
  parameter int unsigned N_CAN  = 4,
  parameter int unsigned N_DMA  = 8,
  parameter int unsigned N_TMR  = 4,
  parameter int unsigned ADDR_W = 8,
  localparam int unsigned NT    = N_UART + N_GEM + N_USB + N_CAN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic [NT-1:0]     periph_rst_o,
  output logic [NT-1:0]     periph_pulse_o,
  output logic [N_DMA-1:0]  dma_rst_o,
  output logic [N_DMA-1:0]  dma_pulse_o
);
  localparam int unsigned IDX_W  = ADDR_W - 2;
  localparam int unsigned S_DMA  = 0;
  localparam int unsigned S_TMR  = NT + 1;
  localparam int unsigned S_SPR  = NT + 2;
  localparam int unsigned NS     = NT + 3;

  logic [NS-1:0] sel;
  logic [NS-1:0] slot_lvl;
  logic [NS-1:0] slot_pls;
  word_t         slot_val [NS];
  word_t         rd_acc   [NS+1];

  prb_decode #(.IDX_W(IDX_W), .NS(NS)) u_dec (
    .idx_i (addr_i[ADDR_W-1:2]),
    .sel_o (sel)
  );

  for (genvar s = 0; s < NS; s++) begin : g_slot
    localparam int unsigned SW = (s == S_TMR) ? N_TMR : 1;
    prb_slot #(.W(SW), .RST({SW{1'b1}})) u_slot (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (wr_en_i & sel[s]),
      .wdata_i (wdata_i),
      .val_o   (slot_val[s]),
      .lvl_o   (slot_lvl[s]),
      .pls_o   (slot_pls[s])
    );
  end

  // read mux as an OR chain over decoded selects
  assign rd_acc[0] = '0;
  for (genvar s = 0; s < NS; s++) begin : g_rd
    assign rd_acc[s+1] = rd_acc[s] | (sel[s] ? slot_val[s] : '0);
  end
  assign rdata_o = rd_acc[NS];

  for (genvar k = 0; k < NT; k++) begin : g_tgt
    assign periph_rst_o[k]   = slot_lvl[k+1];
    assign periph_pulse_o[k] = slot_pls[k+1];
  end

  for (genvar c = 0; c < N_DMA; c++) begin : g_dma
    assign dma_rst_o[c]   = slot_lvl[S_DMA];
    assign dma_pulse_o[c] = slot_pls[S_DMA];
  end

  logic unused_bits;
  assign unused_bits = ^{slot_pls[S_TMR], slot_pls[S_SPR], slot_lvl[S_TMR],
                         slot_lvl[S_SPR], addr_i[1:0]};

  // R6
  dma_pulse_lvl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_pulse_o != '0) |-> (dma_rst_o != $past(dma_rst_o)));
  // R9
  unmapped_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (sel == '0)) |=> ((periph_pulse_o == '0) && (dma_pulse_o == '0)));
endmodule

// File: tb/sim_periph_rst_bank.sv
`timescale 1ns/1ps
module sim_periph_rst_bank;
  localparam int NT = 10;
  localparam int ND = 8;
  localparam int NW = 64;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic [NT-1:0] p_rst, p_pls;
  logic [ND-1:0] d_rst, d_pls;

  int n_vec = 0;
  int n_bad = 0;
  logic [31:0] mq [NW];

  always #2 clk = ~clk;

  periph_rst_bank u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .periph_rst_o(p_rst),
    .periph_pulse_o(p_pls), .dma_rst_o(d_rst), .dma_pulse_o(d_pls)
  );

  function automatic logic [31:0] wmask(int w);
    if (w == 11) return 32'hF;
    if (w <= 12) return 32'h1;
    return 32'h0;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_levels();
    logic [NT-1:0] el;
    logic [ND-1:0] ed;
    for (int k = 0; k < NT; k++) el[k] = mq[k+1][0];
    ed = {ND{mq[0][0]}};
    chk(p_rst == el, "R10", 32'(p_rst), 32'(el));
    chk(d_rst == ed, "R6",  32'(d_rst), 32'(ed));
  endtask

  task automatic do_write(int w, logic [31:0] d);
    logic          chg;
    logic [NT-1:0] ep;
    logic [ND-1:0] edp;
    string         tg;
    @(negedge clk);
    addr = 8'(w * 4); wdata = d; wr_en = 1;
    chg = (w <= 12) && (d[0] != mq[w][0]);
    ep = '0; edp = '0;
    if (chg && w == 0) edp = '1;
    if (chg && w >= 1 && w <= NT) ep[w-1] = 1'b1;
    mq[w] = mq[w] & ~wmask(w) | (d & wmask(w));
    @(negedge clk);
    wr_en = 0;
    tg = (w > 12) ? "R9" : (w >= 11) ? "R8" : !chg ? "R4" : (w == 0) ? "R6" : "R7";
    chk(p_pls == ep,  tg, 32'(p_pls), 32'(ep));
    chk(d_pls == edp, tg, 32'(d_pls), 32'(edp));
    tg = (w > 12) ? "R9" : (w == 11) ? "R2" : "R5";
    chk(rdata == mq[w], tg, rdata, mq[w]);
    chk_levels();
    @(negedge clk);
    chk((p_pls == '0) && (d_pls == '0), "R3", {p_pls, d_pls}, 32'h0);
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog act=%h exp=%h", 32'h0, 32'h1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int w = 0; w < NW; w++) mq[w] = wmask(w) & ((w == 11) ? 32'hF : 32'h1);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 / R2 reset sweep
    for (int w = 0; w < NW; w++) begin
      addr = 8'(w * 4);
      #1;
      chk(rdata == mq[w], (w == 11) ? "R2" : (w > 12) ? "R9" : "R1", rdata, mq[w]);
    end
    chk((p_rst == '1) && (d_rst == '1), "R1", {p_rst, d_rst}, 32'h3FFFF);
    chk((p_pls == '0) && (d_pls == '0), "R1", {p_pls, d_pls}, 32'h0);
    // R7 word sweep with change / repeat patterns
    for (int w = 0; w < NW; w++) begin
      do_write(w, 32'hFFFF_FFFE);
      do_write(w, 32'h0000_0000);
      do_write(w, 32'hA5A5_A5A5);
      do_write(w, 32'h0000_0001);
    end
    // R5 re-read all words after sweep
    for (int w = 0; w < NW; w++) begin
      @(negedge clk);
      addr = 8'(w * 4);
      #1;
      chk(rdata == mq[w], "R5", rdata, mq[w]);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule